// File: doc/BRIEF.md
# Update-Protocol Snooping Cache Controller

This block is the coherence controller for one small write-back cache on a snooping bus. It follows an update protocol. When a processor writes data that other caches also hold, the controller sends the written word on the bus, and the other copies are overwritten with it. No copy is invalidated. The cache is direct-mapped and each line holds one word. A resident line is always in one of four states: exclusive-clean, shared-clean, shared-dirty (the owner of shared data that memory lacks) or dirty. A line that has never been filled, or whose tag does not match, counts as absent.

The processor side is a request interface. The processor holds `cpu_req`, `cpu_we`, `cpu_addr` and `cpu_wdata` steady until `cpu_done` pulses. The controller requests the bus and holds its command until `bus_gnt` arrives. A transaction completes in the single cycle in which request and grant are both high. In that cycle the controller samples the wired-OR `shared_in` and the memory word `bus_rdata`. As a snooper, it watches `snp_valid` and `snp_cmd`, answers in the same cycle on `shared_out`, and drives `flush_valid` with the line's word when it must supply dirty data. The bus never grants this cache in a cycle that also carries another cache's transaction.

Top module: `dragon_upd_cache`

## Requirements
- R1: After reset every line is absent. The first access to any address issues a bus read, and a snoop to any address leaves `shared_out` low.
- R2: A read that hits a line in any resident state returns the stored word with `cpu_done` high in the cycle the request is presented. No bus request is made.
- R3: A read miss issues a bus read (command 01) for the address and fills the line with `bus_rdata`. The line becomes shared-clean if `shared_in` is high at the grant, or exclusive-clean if it is low. The fetched word is returned.
- R4: A miss that replaces a dirty or shared-dirty line first issues a write-back (command 11) carrying the victim's address and word, then the bus read. A clean victim is dropped without a bus transaction.
- R5: A write that hits an exclusive-clean or dirty line stores the word, leaves the line dirty, and completes in the request cycle with no bus request.
- R6: A write that hits a shared-clean or shared-dirty line issues an update (command 10) carrying the address and word. The local copy is written only at that grant. The line becomes shared-dirty if `shared_in` is high, or dirty if it is low.
- R7: A write miss issues a bus read. If `shared_in` is high at that grant, the controller then issues an update with the word and ends shared-dirty. Otherwise it writes the word at once and ends dirty.
- R8: A snooped read or update whose address matches a resident line drives `shared_out` high in the same cycle. Any other snoop, including a snooped write-back, leaves it low.
- R9: A snooped read that matches a dirty or shared-dirty line raises `flush_valid` with the line's word in the same cycle, and the line ends shared-dirty. A match on an exclusive-clean line moves it to shared-clean with no flush.
- R10: A snooped update that matches a resident line overwrites its word, and the line ends shared-clean. A shared-dirty owner is demoted.
- R11: A processor request presented in a cycle with `snp_valid` high is not completed in that cycle. It is serviced after the snoop.
- R12: While the controller requests the bus and has no grant, it holds the command and address. When it does not request, `bus_cmd` is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until done |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write word |
| cpu_done | output | 1 | Request completes this cycle |
| cpu_rdata | output | DATA_W | Read word, valid with cpu_done |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant; transaction occurs when req and gnt are high |
| bus_cmd | output | 2 | 01 read, 10 update, 11 write-back, 00 none |
| bus_addr | output | ADDR_W | Transaction address |
| bus_data | output | DATA_W | Update or write-back word |
| bus_rdata | input | DATA_W | Memory word for a granted read |
| shared_in | input | 1 | Wired-OR shared line, sampled at grant |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same coding as bus_cmd |
| snp_addr | input | ADDR_W | Snooped address |
| snp_data | input | DATA_W | Snooped update word |
| shared_out | output | 1 | This cache holds the snooped line |
| flush_valid | output | 1 | This cache supplies dirty data |
| flush_data | output | DATA_W | Flushed word |

## Verification
The assertions check on every cycle that a pending request holds its command and address, that the command is idle without a request, and that an update always carries the processor's write word. They also check that flushes and shared responses appear only for matching snoops, and that nothing completes while a snoop occupies the cycle. Only the bench scenarios can show the state a line ends in and the words that move between bus and cache. The bench runs a reference model of every line, drives sweeps of reads, writes and snoops, and varies the grant latency. It compares each bus transaction sequence, each returned word, each shared response and each flush against the model.

// File: rtl/dragon_pkg.sv
package dragon_pkg;
  typedef enum logic [2:0] {
    LN_ABSENT  = 3'd0,
    LN_EXCL    = 3'd1,
    LN_SHCLEAN = 3'd2,
    LN_SHMOD   = 3'd3,
    LN_MOD     = 3'd4
  } line_st_e;

  typedef enum logic [1:0] {
    CMD_NONE = 2'b00,
    CMD_READ = 2'b01,
    CMD_UPD  = 2'b10,
    CMD_WB   = 2'b11
  } bus_cmd_e;

  typedef enum logic [1:0] {
    CT_IDLE = 2'd0,
    CT_WB   = 2'd1,
    CT_RD   = 2'd2,
    CT_UPD  = 2'd3
  } ctl_st_e;

  function automatic logic is_dirty(line_st_e s);
    return (s == LN_MOD) || (s == LN_SHMOD);
  endfunction
endpackage

// File: rtl/dragon_line_store.sv
module dragon_line_store
  import dragon_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output line_st_e          a_state,
  output logic [TAG_W-1:0]  a_tag,
  output logic [DATA_W-1:0] a_data,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output line_st_e          b_state,
  output logic [TAG_W-1:0]  b_tag,
  output logic [DATA_W-1:0] b_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  line_st_e          wr_state,
  input  logic              wr_tag_en,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic              wr_data_en,
  input  logic [DATA_W-1:0] wr_data
);
  line_st_e          st_arr   [LINES];
  logic [TAG_W-1:0]  tag_arr  [LINES];
  logic [DATA_W-1:0] data_arr [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic              sel;
    line_st_e          st_r;
    logic [TAG_W-1:0]  tag_r;
    logic [DATA_W-1:0] data_r;

    assign sel = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_r <= LN_ABSENT;
      end else if (sel) begin
        st_r <= wr_state;
      end
    end

    always_ff @(posedge clk) begin
      if (sel && wr_tag_en) begin
        tag_r <= wr_tag;
      end
      if (sel && wr_data_en) begin
        data_r <= wr_data;
      end
    end

    assign st_arr[g]   = st_r;
    assign tag_arr[g]  = tag_r;
    assign data_arr[g] = data_r;
  end

  assign a_state = st_arr[rd_a_idx];
  assign a_tag   = tag_arr[rd_a_idx];
  assign a_data  = data_arr[rd_a_idx];
  assign b_state = st_arr[rd_b_idx];
  assign b_tag   = tag_arr[rd_b_idx];
  assign b_data  = data_arr[rd_b_idx];
endmodule

// File: rtl/dragon_snoop.sv
module dragon_snoop
  import dragon_pkg::*;
#(
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              snp_valid,
  input  bus_cmd_e          snp_cmd,
  input  logic [TAG_W-1:0]  snp_tag,
  input  logic              own_gnt,
  input  line_st_e          line_state,
  input  logic [TAG_W-1:0]  line_tag,
  input  logic [DATA_W-1:0] line_data,
  output logic              shared_o,
  output logic              flush_o,
  output logic [DATA_W-1:0] flush_data_o,
  output logic              wr_en_o,
  output line_st_e          wr_state_o,
  output logic              wr_data_en_o
);
  logic match;

  assign match        = snp_valid && !own_gnt &&
                        (line_state != LN_ABSENT) && (line_tag == snp_tag);
  assign flush_data_o = line_data;

  always_comb begin
    shared_o     = 1'b0;
    flush_o      = 1'b0;
    wr_en_o      = 1'b0;
    wr_state_o   = line_state;
    wr_data_en_o = 1'b0;
    if (match) begin
      unique case (snp_cmd)
        CMD_READ: begin
          shared_o = 1'b1;
          if (is_dirty(line_state)) begin
            flush_o    = 1'b1;
            wr_en_o    = (line_state == LN_MOD);
            wr_state_o = LN_SHMOD;
          end else if (line_state == LN_EXCL) begin
            wr_en_o    = 1'b1;
            wr_state_o = LN_SHCLEAN;
          end
        end
        CMD_UPD: begin
          shared_o     = 1'b1;
          wr_en_o      = 1'b1;
          wr_data_en_o = 1'b1;
          wr_state_o   = LN_SHCLEAN;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dragon_requester.sv
module dragon_requester
  import dragon_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              snp_valid,
  input  line_st_e          line_state,
  input  logic [TAG_W-1:0]  line_tag,
  input  logic [DATA_W-1:0] line_data,
  output logic              bus_req,
  input  logic              bus_gnt,
  output bus_cmd_e          bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_data,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              shared_in,
  output logic              wr_en,
  output line_st_e          wr_state,
  output logic              wr_tag_en,
  output logic              wr_data_en,
  output logic [DATA_W-1:0] wr_data
);
  ctl_st_e           ctl_q, ctl_d;
  logic [TAG_W-1:0]  cpu_tag;
  logic [IDX_W-1:0]  cpu_idx;
  logic              hit;
  logic              granted;

  assign cpu_tag = cpu_addr[ADDR_W-1:IDX_W];
  assign cpu_idx = cpu_addr[IDX_W-1:0];
  assign hit     = (line_state != LN_ABSENT) && (line_tag == cpu_tag);
  assign granted = bus_req && bus_gnt;

  always_comb begin
    ctl_d      = ctl_q;
    cpu_done   = 1'b0;
    cpu_rdata  = line_data;
    bus_req    = 1'b0;
    bus_cmd    = CMD_NONE;
    bus_addr   = cpu_addr;
    bus_data   = cpu_wdata;
    wr_en      = 1'b0;
    wr_state   = line_state;
    wr_tag_en  = 1'b0;
    wr_data_en = 1'b0;
    wr_data    = cpu_wdata;
    unique case (ctl_q)
      CT_IDLE: begin
        if (cpu_req && !snp_valid) begin
          if (hit) begin
            if (!cpu_we) begin
              cpu_done = 1'b1;
            end else if ((line_state == LN_EXCL) || (line_state == LN_MOD)) begin
              wr_en      = 1'b1;
              wr_data_en = 1'b1;
              wr_state   = LN_MOD;
              cpu_done   = 1'b1;
            end else begin
              ctl_d = CT_UPD;
            end
          end else begin
            ctl_d = is_dirty(line_state) ? CT_WB : CT_RD;
          end
        end
      end
      CT_WB: begin
        bus_req  = 1'b1;
        bus_cmd  = CMD_WB;
        bus_addr = {line_tag, cpu_idx};
        bus_data = line_data;
        if (granted) begin
          ctl_d = CT_RD;
        end
      end
      CT_RD: begin
        bus_req = 1'b1;
        bus_cmd = CMD_READ;
        if (granted) begin
          wr_en      = 1'b1;
          wr_tag_en  = 1'b1;
          wr_data_en = 1'b1;
          wr_data    = bus_rdata;
          if (!cpu_we) begin
            wr_state  = shared_in ? LN_SHCLEAN : LN_EXCL;
            cpu_rdata = bus_rdata;
            cpu_done  = 1'b1;
            ctl_d     = CT_IDLE;
          end else if (shared_in) begin
            wr_state = LN_SHCLEAN;
            ctl_d    = CT_UPD;
          end else begin
            wr_data  = cpu_wdata;
            wr_state = LN_MOD;
            cpu_done = 1'b1;
            ctl_d    = CT_IDLE;
          end
        end
      end
      CT_UPD: begin
        bus_req = 1'b1;
        bus_cmd = CMD_UPD;
        if (granted) begin
          wr_en      = 1'b1;
          wr_data_en = 1'b1;
          wr_state   = shared_in ? LN_SHMOD : LN_MOD;
          cpu_done   = 1'b1;
          ctl_d      = CT_IDLE;
        end
      end
      default: ctl_d = CT_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= CT_IDLE;
    end else begin
      ctl_q <= ctl_d;
    end
  end
endmodule

// File: rtl/dragon_upd_cache.sv
module dragon_upd_cache
  import dragon_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int LINES  = 4,
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_data,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              shared_in,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [DATA_W-1:0] snp_data,
  output logic              shared_out,
  output logic              flush_valid,
  output logic [DATA_W-1:0] flush_data
);
  line_st_e          a_state, b_state;
  logic [TAG_W-1:0]  a_tag, b_tag;
  logic [DATA_W-1:0] a_data, b_data;

  logic              rq_wr_en, rq_tag_en, rq_data_en;
  line_st_e          rq_state;
  logic [DATA_W-1:0] rq_data;
  bus_cmd_e          rq_cmd;

  logic              sn_wr_en, sn_data_en;
  line_st_e          sn_state;

  logic              st_wr_en, st_tag_en, st_data_en;
  logic [IDX_W-1:0]  st_idx;
  line_st_e          st_state;
  logic [DATA_W-1:0] st_data;

  dragon_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_a_idx   (cpu_addr[IDX_W-1:0]),
    .a_state    (a_state),
    .a_tag      (a_tag),
    .a_data     (a_data),
    .rd_b_idx   (snp_addr[IDX_W-1:0]),
    .b_state    (b_state),
    .b_tag      (b_tag),
    .b_data     (b_data),
    .wr_en      (st_wr_en),
    .wr_idx     (st_idx),
    .wr_state   (st_state),
    .wr_tag_en  (st_tag_en),
    .wr_tag     (cpu_addr[ADDR_W-1:IDX_W]),
    .wr_data_en (st_data_en),
    .wr_data    (st_data)
  );

  dragon_requester #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_req (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_req    (cpu_req),
    .cpu_we     (cpu_we),
    .cpu_addr   (cpu_addr),
    .cpu_wdata  (cpu_wdata),
    .cpu_done   (cpu_done),
    .cpu_rdata  (cpu_rdata),
    .snp_valid  (snp_valid),
    .line_state (a_state),
    .line_tag   (a_tag),
    .line_data  (a_data),
    .bus_req    (bus_req),
    .bus_gnt    (bus_gnt),
    .bus_cmd    (rq_cmd),
    .bus_addr   (bus_addr),
    .bus_data   (bus_data),
    .bus_rdata  (bus_rdata),
    .shared_in  (shared_in),
    .wr_en      (rq_wr_en),
    .wr_state   (rq_state),
    .wr_tag_en  (rq_tag_en),
    .wr_data_en (rq_data_en),
    .wr_data    (rq_data)
  );

  dragon_snoop #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
    .snp_valid    (snp_valid),
    .snp_cmd      (bus_cmd_e'(snp_cmd)),
    .snp_tag      (snp_addr[ADDR_W-1:IDX_W]),
    .own_gnt      (bus_req && bus_gnt),
    .line_state   (b_state),
    .line_tag     (b_tag),
    .line_data    (b_data),
    .shared_o     (shared_out),
    .flush_o      (flush_valid),
    .flush_data_o (flush_data),
    .wr_en_o      (sn_wr_en),
    .wr_state_o   (sn_state),
    .wr_data_en_o (sn_data_en)
  );

  assign bus_cmd = rq_cmd;

  // Snoop writes and requester writes never fall in the same cycle:
  // the requester stalls on snp_valid and the snooper ignores granted cycles.
  always_comb begin
    if (sn_wr_en) begin
      st_wr_en   = 1'b1;
      st_idx     = snp_addr[IDX_W-1:0];
      st_state   = sn_state;
      st_tag_en  = 1'b0;
      st_data_en = sn_data_en;
      st_data    = snp_data;
    end else begin
      st_wr_en   = rq_wr_en;
      st_idx     = cpu_addr[IDX_W-1:0];
      st_state   = rq_state;
      st_tag_en  = rq_tag_en;
      st_data_en = rq_data_en;
      st_data    = rq_data;
    end
  end
endmodule

// File: rtl/dragon_upd_cache_chk.sv
module dragon_upd_cache_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_we,
  input logic [DATA_W-1:0] cpu_wdata,
  input logic              cpu_done,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic [1:0]        bus_cmd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_data,
  input logic              snp_valid,
  input logic [1:0]        snp_cmd,
  input logic              shared_out,
  input logic              flush_valid
);
  assert_hold_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_cmd) && $stable(bus_addr)));

  assert_idle_cmd_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |-> (bus_cmd == 2'b00));

  assert_upd_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_cmd == 2'b10) |-> (cpu_we && bus_data == cpu_wdata));

  assert_flush_on_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> (snp_valid && snp_cmd == 2'b01 && shared_out));

  assert_shared_on_snoop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    shared_out |-> (snp_valid && (snp_cmd == 2'b01 || snp_cmd == 2'b10)));

  assert_snoop_stalls_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && !bus_gnt) |-> !cpu_done);

  assert_local_done_no_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |-> (bus_gnt || !bus_req));
endmodule

bind dragon_upd_cache dragon_upd_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cpu_we      (cpu_we),
  .cpu_wdata   (cpu_wdata),
  .cpu_done    (cpu_done),
  .bus_req     (bus_req),
  .bus_gnt     (bus_gnt),
  .bus_cmd     (bus_cmd),
  .bus_addr    (bus_addr),
  .bus_data    (bus_data),
  .snp_valid   (snp_valid),
  .snp_cmd     (snp_cmd),
  .shared_out  (shared_out),
  .flush_valid (flush_valid)
);

// File: tb/dragon_upd_cache_tb.sv
`timescale 1ns/1ps
module dragon_upd_cache_tb;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int NL = 4;

  logic          clk, rst_n;
  logic          cpu_req, cpu_we, cpu_done;
  logic [AW-1:0] cpu_addr;
  logic [DW-1:0] cpu_wdata, cpu_rdata;
  logic          bus_req, bus_gnt;
  logic [1:0]    bus_cmd;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_data, bus_rdata;
  logic          shared_in;
  logic          snp_valid;
  logic [1:0]    snp_cmd;
  logic [AW-1:0] snp_addr;
  logic [DW-1:0] snp_data;
  logic          shared_out, flush_valid;
  logic [DW-1:0] flush_data;

  int checks = 0;
  int fails  = 0;
  int gnt_lat = 0;
  int wait_cnt;

  // model: 0 absent, 1 exclusive-clean, 2 shared-clean, 3 shared-dirty, 4 dirty
  int          m_st   [NL];
  int          m_tag  [NL];
  logic [DW-1:0] m_data [NL];

  dragon_upd_cache #(.ADDR_W(AW), .DATA_W(DW), .LINES(NL)) u_dut (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [DW-1:0] mem_word(logic [AW-1:0] a);
    return DW'(a) * 16'd37 + 16'h0105;
  endfunction

  assign bus_rdata = mem_word(bus_addr);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) wait_cnt <= 0;
    else if (bus_req && !bus_gnt) wait_cnt <= wait_cnt + 1;
    else wait_cnt <= 0;
  end
  assign bus_gnt = bus_req && (wait_cnt >= gnt_lat);

  task automatic check(input string rq, input string what, input logic ok,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // R8, R9, R10 model of a snooped transaction
  task automatic model_snoop(input logic [1:0] c, input logic [AW-1:0] a, input logic [DW-1:0] d);
    int ix = int'(a) % NL;
    int tg = int'(a) / NL;
    if (m_st[ix] != 0 && m_tag[ix] == tg) begin
      if (c == 2'b01) begin
        if (m_st[ix] == 4) m_st[ix] = 3;
        else if (m_st[ix] == 1) m_st[ix] = 2;
      end else if (c == 2'b10) begin
        m_data[ix] = d;   // R10 overwrite and demote
        m_st[ix]   = 2;
      end
    end
  endtask

  task automatic do_snoop(input logic [1:0] c, input logic [AW-1:0] a, input logic [DW-1:0] d);
    int ix = int'(a) % NL;
    int tg = int'(a) / NL;
    logic pres = (m_st[ix] != 0) && (m_tag[ix] == tg);
    logic exp_sh = pres && (c == 2'b01 || c == 2'b10);
    logic exp_fl = pres && (c == 2'b01) && (m_st[ix] == 3 || m_st[ix] == 4);
    logic [DW-1:0] exp_fd = m_data[ix];
    @(posedge clk); #1;
    snp_valid = 1'b1; snp_cmd = c; snp_addr = a; snp_data = d;
    @(negedge clk);
    check("R8", "shared_out", shared_out == exp_sh, 32'(shared_out), 32'(exp_sh));
    check("R9", "flush_valid", flush_valid == exp_fl, 32'(flush_valid), 32'(exp_fl));
    if (exp_fl) check("R9", "flush_data", flush_data == exp_fd, 32'(flush_data), 32'(exp_fd));
    @(posedge clk); #1;
    snp_valid = 1'b0;
    model_snoop(c, a, d);
  endtask

  task automatic do_op(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] wd, input logic sh);
    int ix = int'(a) % NL;
    int tg = int'(a) / NL;
    logic hit = (m_st[ix] != 0) && (m_tag[ix] == tg);
    string rq;
    int exp_n = 0;
    int got_n = 0;
    int cyc = 0;
    logic [1:0]    e_cmd [4];
    logic [AW-1:0] e_addr [4];
    logic [DW-1:0] e_data [4];
    logic [1:0]    g_cmd [4];
    logic [AW-1:0] g_addr [4];
    logic [DW-1:0] g_data [4];
    logic [DW-1:0] exp_rd = '0;
    logic [DW-1:0] got_rd = '0;
    logic seq_ok;
    if (!we && hit) begin
      rq = "R2"; exp_rd = m_data[ix];
    end else if (we && hit && (m_st[ix] == 1 || m_st[ix] == 4)) begin
      rq = "R5"; m_st[ix] = 4; m_data[ix] = wd;
    end else if (we && hit) begin
      rq = "R6";
      e_cmd[0] = 2'b10; e_addr[0] = a; e_data[0] = wd; exp_n = 1;
      m_st[ix] = sh ? 3 : 4; m_data[ix] = wd;
    end else begin
      rq = we ? "R7" : "R3";
      if (m_st[ix] == 3 || m_st[ix] == 4) begin
        rq = "R4";
        e_cmd[0] = 2'b11; e_addr[0] = AW'(m_tag[ix] * NL + ix); e_data[0] = m_data[ix];
        exp_n = 1;
      end
      if (m_st[ix] == 0) rq = {rq, "/R1"};
      e_cmd[exp_n] = 2'b01; e_addr[exp_n] = a; e_data[exp_n] = '0; exp_n++;
      m_tag[ix] = tg;
      if (!we) begin
        m_st[ix] = sh ? 2 : 1; m_data[ix] = mem_word(a); exp_rd = mem_word(a);
      end else begin
        if (sh) begin
          e_cmd[exp_n] = 2'b10; e_addr[exp_n] = a; e_data[exp_n] = wd; exp_n++;
          m_st[ix] = 3;
        end else begin
          m_st[ix] = 4;
        end
        m_data[ix] = wd;
      end
    end
    @(posedge clk); #1;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; shared_in = sh;
    forever begin
      @(negedge clk);
      cyc++;
      if (bus_req && bus_gnt && got_n < 4) begin
        g_cmd[got_n] = bus_cmd; g_addr[got_n] = bus_addr; g_data[got_n] = bus_data; got_n++;
      end
      if (cpu_done) begin
        got_rd = cpu_rdata;
        break;
      end
      if (cyc > 40) break;
    end
    @(posedge clk); #1;
    cpu_req = 1'b0;
    seq_ok = (got_n == exp_n) && (cyc <= 40);
    for (int i = 0; i < exp_n && i < got_n; i++) begin
      if (g_cmd[i] != e_cmd[i] || g_addr[i] != e_addr[i]) seq_ok = 1'b0;
      if (e_cmd[i] != 2'b01 && g_data[i] != e_data[i]) seq_ok = 1'b0;
    end
    check(rq, "bus sequence", seq_ok,
          {8'(got_n), 6'd0, (got_n > 0) ? g_cmd[0] : 2'b00, (got_n > 0) ? g_addr[0] : 8'h00, 8'(cyc)},
          {8'(exp_n), 6'd0, (exp_n > 0) ? e_cmd[0] : 2'b00, (exp_n > 0) ? e_addr[0] : 8'h00, 8'd0});
    if (!we) check(rq, "read word", got_rd == exp_rd, 32'(got_rd), 32'(exp_rd));
    if (exp_n == 0) check(rq, "local latency", cyc == 1, 32'(cyc), 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] rng = 32'h1234_5678;
    cpu_req = 0; cpu_we = 0; cpu_addr = '0; cpu_wdata = '0; shared_in = 0;
    snp_valid = 0; snp_cmd = 2'b00; snp_addr = '0; snp_data = '0;
    for (int i = 0; i < NL; i++) begin m_st[i] = 0; m_tag[i] = 0; m_data[i] = '0; end
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1", "reset done", cpu_done == 1'b0, 32'(cpu_done), 0);
    check("R12", "reset bus_cmd", bus_req == 1'b0 && bus_cmd == 2'b00, 32'(bus_cmd), 0);
    // R1: every line absent after reset
    for (int i = 0; i < NL; i++) do_snoop(2'b01, AW'(i), '0);

    // Directed sweep: every line state against every processor operation and shared value
    for (int lat = 0; lat < 3; lat++) begin
      gnt_lat = lat;
      for (int sh = 0; sh < 2; sh++) begin
        do_op(1'b0, 8'h01, '0, sh[0]);                 // R3 fill
        do_op(1'b0, 8'h01, '0, 1'b0);                  // R2 hit
        do_op(1'b1, 8'h01, 16'hA000 + 16'(lat), sh[0]); // R5 or R6
        do_snoop(2'b01, 8'h01, '0);                    // R9
        do_op(1'b1, 8'h01, 16'hB100, sh[0]);           // R6 from shared-dirty
        do_snoop(2'b10, 8'h01, 16'hC0DE);              // R10
        do_op(1'b0, 8'h01, '0, 1'b0);                  // R2 sees update
        do_op(1'b1, 8'h05, 16'hD00D, sh[0]);           // R7 miss, clean victim
        do_op(1'b0, 8'h09, '0, sh[0]);                 // R4 dirty victim
        do_snoop(2'b11, 8'h09, 16'hFFFF);              // R8 write-back ignored
        do_op(1'b1, 8'h09, 16'h1234, 1'b0);
      end
    end

    // R11: request alongside a snoop waits for the snoop to end
    gnt_lat = 0;
    do_op(1'b0, 8'h06, '0, 1'b0);
    @(posedge clk); #1;
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 8'h06;
    snp_valid = 1'b1; snp_cmd = 2'b01; snp_addr = 8'h03; snp_data = '0;
    @(negedge clk);
    check("R11", "done during snoop", cpu_done == 1'b0, 32'(cpu_done), 0);
    @(posedge clk); #1;
    snp_valid = 1'b0;
    model_snoop(2'b01, 8'h03, '0);
    @(negedge clk);
    check("R11", "done after snoop", cpu_done == 1'b1, 32'(cpu_done), 1);
    check("R11", "read word", cpu_rdata == m_data[2], 32'(cpu_rdata), 32'(m_data[2]));
    @(posedge clk); #1;
    cpu_req = 1'b0;

    // Pseudo-random mix over 3 tags x 4 lines
    for (int n = 0; n < 2400; n++) begin
      logic [AW-1:0] a;
      rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
      gnt_lat = (n / 800);
      a = AW'((rng[3:2] % 3) * NL + int'(rng[1:0]));
      if (rng[7:5] < 3'd5)
        do_op(rng[8], a, rng[31:16], rng[9]);
      else
        do_snoop((rng[11:10] == 2'b00) ? 2'b01 : rng[11:10], a, rng[31:16]);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule